// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Page-Map Walk

This block sits between a CPU and main memory and turns each virtual address into a physical one. A virtual address is the virtual page number in its upper bits and a byte offset in its low bits. The offset passes through unchanged. The page number is replaced by a physical page number. The block looks the page number up in a small fully-associative translation cache first. If it misses, it reads the page's descriptor from a flat page map that lives in main memory. The descriptor's address comes from a base register plus the page number scaled by the descriptor size.

A resident descriptor completes the translation and is written into the cache, so later accesses to that page need no memory read. A non-resident descriptor produces a fault response in place of an address. The operating system's fault handling lies outside this block. The operating system uses a separate invalidate port to drop a cached translation when it evicts a page. A load port sets the page-map base.

Default configuration: 10 offset bits, 22 virtual page bits, 14 physical page bits and an 8-entry cache. That gives 16-bit descriptors of 2 bytes each.

Top module: `xlate_mmu`

## Requirements
- R1: A virtual address splits into VPN = bits [VW+PW-1:PW] and offset = bits [PW-1:0]. A translated physical address is {PPN, offset}.
- R2: A request accepted while its VPN is held valid in the cache gives rspValid high exactly one cycle after acceptance, with rspFault low. No memory read is issued and reqReady stays high.
- R3: On a cache miss, memReqValid rises the cycle after acceptance with memAddr = base + VPN × ENTRY_BYTES. ENTRY_BYTES = ceil((MW+2)/8), which is 2 by default. memReqValid stays high and reqReady stays low until memRspValid.
- R4: A page-map descriptor holds PPN in bits [MW-1:0], the resident flag in bit MW and the dirty flag in bit MW+1. When the resident flag is 1, rspValid rises the cycle after memRspValid, with rspPaddr = {PPN, offset} and rspFault = 0.
- R5: A resident descriptor fetched on a miss is installed in the cache. A later request to the same VPN hits as in R2, and at most one valid entry ever matches a VPN.
- R6: When the resident flag is 0, the response has rspFault = 1. The PPN and dirty fields are ignored, nothing is installed, and a later request to that VPN walks again.
- R7: An invalidate pulse for a VPN clears the valid flag of any matching cache entry, so the next request to it walks. An invalidate for a VPN that is not cached changes nothing.
- R8: A fill goes to the lowest-numbered invalid entry. When every entry is valid, a round-robin pointer picks the victim. The pointer starts at entry 0 and advances by one after each such eviction.
- R9: An active-low synchronous reset invalidates every cache entry, zeroes the base register and the round-robin pointer, and leaves the block idle with reqReady = 1, rspValid = 0 and memReqValid = 0.
- R10: A baseLoad pulse replaces the base register, and every walk that starts afterwards uses the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | VW+PW | Virtual address |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | MW+PW | Physical address |
| rspFault | output | 1 | Page not resident |
| memReqValid | output | 1 | Descriptor read outstanding |
| memAddr | output | MAW | Descriptor byte address |
| memRspValid | input | 1 | Descriptor data valid |
| memRspData | input | MW+2 | Descriptor {dirty, resident, PPN} |
| baseLoad | input | 1 | Load the page-map base |
| baseData | input | MAW | New page-map base |
| invValid | input | 1 | Invalidate strobe |
| invVpn | input | VW | VPN to invalidate |

## Verification
The bench keeps its own model of the eight cache slots and replays a long mixed sweep of hits, walks, faults, invalidates and base changes against it. Whenever all slots are full, the replacement order is exposed. A wrong victim choice shows up later as a walk where a hit was due, or the reverse, and a wrong fill slot after an invalidate does the same. A design that cached faulting pages would hit where a second walk is due. A design that ignored the resident flag would return an address instead of a fault. A design that scaled the page number wrongly, or that kept a stale base, would present a wrong memAddr. A reset that failed to clear the cache would turn the first access after reset into a hit.

// File: rtl/xlate_mmu_pkg.sv
package xlate_mmu_pkg;
  typedef struct packed {
    logic capture;   // latch the accepted request
    logic hitRsp;    // respond from the cache
    logic fill;      // install the fetched descriptor and respond
    logic faultRsp;  // respond with a fault
  } mmuStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } mmuState_t;
endpackage

// File: rtl/xlate_mmu_ctrl.sv
module xlate_mmu_ctrl
  import xlate_mmu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lookupHit,
  input  logic        entryResident,
  input  logic        memRspValid,
  output logic        reqReady,
  output logic        memReqValid,
  output mmuStrobes_t strb
);
  mmuState_t state, stateNext;
  logic accept;

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_WALK);
  assign accept      = reqValid && reqReady;

  always_comb begin
    strb          = '0;
    strb.capture  = accept;
    strb.hitRsp   = accept && lookupHit;
    strb.fill     = (state == ST_WALK) && memRspValid && entryResident;
    strb.faultRsp = (state == ST_WALK) && memRspValid && !entryResident;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept && !lookupHit) stateNext = ST_WALK;
      ST_WALK: if (memRspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R3: a walk holds its read and blocks new requests until data returns
  p_walk_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> (memReqValid && !reqReady));

  // R2: a request that hits never starts a walk
  p_hit_no_walk_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lookupHit) |=> (!memReqValid && reqReady));
endmodule

// File: rtl/xlate_mmu_datapath.sv
module xlate_mmu_datapath
  import xlate_mmu_pkg::*;
#(
  parameter int PW      = 10,
  parameter int VW      = 22,
  parameter int MW      = 14,
  parameter int MAW     = 32,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mmuStrobes_t        strb,
  input  logic [VW+PW-1:0]   reqVaddr,
  input  logic               baseLoad,
  input  logic [MAW-1:0]     baseData,
  input  logic               invValid,
  input  logic [VW-1:0]      invVpn,
  input  logic [MW+1:0]      memRspData,
  output logic               lookupHit,
  output logic               entryResident,
  output logic [MAW-1:0]     memAddr,
  output logic               rspValid,
  output logic [MW+PW-1:0]   rspPaddr,
  output logic               rspFault
);
  localparam int VAW         = VW + PW;
  localparam int EW          = MW + 2;
  localparam int ENTRY_BYTES = (EW + 7) / 8;
  localparam int IW          = $clog2(ENTRIES);

  logic [VW-1:0]      reqVpn;
  logic [PW-1:0]      reqOff;
  logic [VW-1:0]      tlbVpn [ENTRIES];
  logic [MW-1:0]      tlbPpn [ENTRIES];
  logic [ENTRIES-1:0] tlbR;
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] invMatch;
  logic [MW-1:0]      hitPpn;
  logic [MW-1:0]      memPpn;
  logic [VW-1:0]      vpnQ;
  logic [PW-1:0]      offQ;
  logic [MAW-1:0]     baseQ;
  logic [IW-1:0]      rrPtr;
  logic [IW-1:0]      freeIdx;
  logic [IW-1:0]      victimIdx;
  logic               anyFree;

  assign reqVpn        = reqVaddr[VAW-1:PW];
  assign reqOff        = reqVaddr[PW-1:0];
  assign memPpn        = memRspData[MW-1:0];
  assign entryResident = memRspData[MW];

  // Parallel tag compare for lookup and invalidate
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hitVec[i]   = tlbR[i] && (tlbVpn[i] == reqVpn);
    assign invMatch[i] = tlbR[i] && (tlbVpn[i] == invVpn);
  end

  assign lookupHit = |hitVec;

  always_comb begin
    hitPpn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitVec[i]) hitPpn = hitPpn | tlbPpn[i];
  end

  // Lowest free slot wins; descending scan leaves the lowest index
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!tlbR[i]) begin
        anyFree = 1'b1;
        freeIdx = IW'(i);
      end
  end

  assign victimIdx = anyFree ? freeIdx : rrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strb.fill && !anyFree) begin
      rrPtr <= (rrPtr == IW'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fill) begin
      tlbVpn[victimIdx] <= vpnQ;
      tlbPpn[victimIdx] <= memPpn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlbR <= '0;
    end else begin
      if (strb.fill) tlbR[victimIdx] <= 1'b1;
      for (int i = 0; i < ENTRIES; i++)
        if (invValid && (invMatch[i] ||
            (strb.fill && victimIdx == IW'(i) && vpnQ == invVpn)))
          tlbR[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
    end else if (baseLoad) begin
      baseQ <= baseData;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      vpnQ <= reqVpn;
      offQ <= reqOff;
    end
  end

  assign memAddr = baseQ + MAW'(vpnQ) * MAW'(ENTRY_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspPaddr <= '0;
    end else begin
      rspValid <= strb.hitRsp || strb.fill || strb.faultRsp;
      rspFault <= strb.faultRsp;
      if (strb.hitRsp)        rspPaddr <= {hitPpn, reqOff};
      else if (strb.fill)     rspPaddr <= {memPpn, offQ};
      else if (strb.faultRsp) rspPaddr <= '0;
    end
  end

  // R5: no VPN is ever held valid in two slots
  p_single_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R7: after an invalidate no slot that matched stays valid
  p_inv_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=> (($past(invMatch) & tlbR) == '0));

  // R8: the chosen victim slot is valid after a fill
  p_fill_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fill && !invValid) |=> tlbR[$past(victimIdx)]);

  // R6: a fault only appears on a response
  p_fault_on_rsp_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspValid);
endmodule

// File: rtl/xlate_mmu.sv
module xlate_mmu
  import xlate_mmu_pkg::*;
#(
  parameter int PW      = 10,
  parameter int VW      = 22,
  parameter int MW      = 14,
  parameter int MAW     = 32,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VW+PW-1:0] reqVaddr,
  output logic             rspValid,
  output logic [MW+PW-1:0] rspPaddr,
  output logic             rspFault,
  output logic             memReqValid,
  output logic [MAW-1:0]   memAddr,
  input  logic             memRspValid,
  input  logic [MW+1:0]    memRspData,
  input  logic             baseLoad,
  input  logic [MAW-1:0]   baseData,
  input  logic             invValid,
  input  logic [VW-1:0]    invVpn
);
  mmuStrobes_t strb;
  logic lookupHit;
  logic entryResident;

  xlate_mmu_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .lookupHit    (lookupHit),
    .entryResident(entryResident),
    .memRspValid  (memRspValid),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .strb         (strb)
  );

  xlate_mmu_datapath #(
    .PW(PW), .VW(VW), .MW(MW), .MAW(MAW), .ENTRIES(ENTRIES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqVaddr     (reqVaddr),
    .baseLoad     (baseLoad),
    .baseData     (baseData),
    .invValid     (invValid),
    .invVpn       (invVpn),
    .memRspData   (memRspData),
    .lookupHit    (lookupHit),
    .entryResident(entryResident),
    .memAddr      (memAddr),
    .rspValid     (rspValid),
    .rspPaddr     (rspPaddr),
    .rspFault     (rspFault)
  );
endmodule

// File: tb/xlate_mmu_test.sv
`timescale 1ns/1ps
module xlate_mmu_test;
  localparam int PW = 10, VW = 22, MW = 14, MAW = 32, ENTRIES = 8;
  localparam int ENTRY_BYTES = (MW + 2 + 7) / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [VW+PW-1:0] reqVaddr = '0;
  logic rspValid;
  logic [MW+PW-1:0] rspPaddr;
  logic rspFault;
  logic memReqValid;
  logic [MAW-1:0] memAddr;
  logic memRspValid = 1'b0;
  logic [MW+1:0] memRspData = '0;
  logic baseLoad = 1'b0;
  logic [MAW-1:0] baseData = '0;
  logic invValid = 1'b0;
  logic [VW-1:0] invVpn = '0;

  xlate_mmu #(.PW(PW), .VW(VW), .MW(MW), .MAW(MAW), .ENTRIES(ENTRIES)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .memReqValid(memReqValid), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .baseLoad(baseLoad),
    .baseData(baseData), .invValid(invValid), .invVpn(invVpn)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;

  // Reference model of the cache, kept from the requirements
  logic [VW-1:0]  mVpn [ENTRIES];
  logic [MW-1:0]  mPpn [ENTRIES];
  bit             mR   [ENTRIES];
  int             mRr;
  logic [MAW-1:0] mBase;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void mClear();
    for (int i = 0; i < ENTRIES; i++) mR[i] = 0;
    mRr = 0;
    mBase = '0;
  endfunction

  function automatic int mFind(input logic [VW-1:0] vpn);
    for (int i = 0; i < ENTRIES; i++)
      if (mR[i] && mVpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void mFill(input logic [VW-1:0] vpn, input logic [MW-1:0] ppn);
    int slot = -1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!mR[i]) slot = i;
    if (slot < 0) begin
      slot = mRr;
      mRr = (mRr + 1) % ENTRIES;
    end
    mVpn[slot] = vpn;
    mPpn[slot] = ppn;
    mR[slot] = 1;
  endfunction

  function automatic void mInv(input logic [VW-1:0] vpn);
    for (int i = 0; i < ENTRIES; i++)
      if (mR[i] && mVpn[i] == vpn) mR[i] = 0;
  endfunction

  // Page map contents: {dirty, resident, ppn}
  function automatic logic [MW+1:0] pmEntry(input logic [VW-1:0] vpn);
    if (vpn == 0)      return {1'b1, 1'b0, 14'h2ABC};
    if (vpn == 4)      return {1'b0, 1'b1, 14'h5};
    if (vpn == 6)      return {1'b0, 1'b1, 14'h2};
    if (vpn % 5 == 0)  return {vpn[0], 1'b0, MW'(vpn * 3)};
    return {vpn[1], 1'b1, MW'(vpn * 7 + 3)};
  endfunction

  task automatic translate(input logic [VW+PW-1:0] va, input string walkTag,
                           input string addrTag,
                           output logic [MW+PW-1:0] pa, output logic flt);
    logic [VW-1:0] vpn;
    logic [PW-1:0] off;
    logic [MW+1:0] ent;
    int idx;
    vpn = va[VW+PW-1:PW];
    off = va[PW-1:0];
    idx = mFind(vpn);
    ent = pmEntry(vpn);
    @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = va;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (idx >= 0) begin
      check(rspValid && !memReqValid, walkTag, "expected cache hit",
            {rspValid, memReqValid}, 2'b10);
      check(rspValid && !rspFault && rspPaddr == {mPpn[idx], off}, "R1",
            "hit physical address", rspPaddr, {mPpn[idx], off});
      check(reqReady, "R2", "ready after hit", reqReady, 1);
      pa = rspPaddr;
      flt = rspFault;
    end else begin
      check(!rspValid && memReqValid, walkTag, "expected walk",
            {rspValid, memReqValid}, 2'b01);
      check(memAddr == mBase + MAW'(vpn) * ENTRY_BYTES, addrTag,
            "descriptor address", memAddr, mBase + MAW'(vpn) * ENTRY_BYTES);
      repeat (2) @(negedge clk);
      check(memReqValid && !reqReady && !rspValid, "R3", "walk held",
            {memReqValid, reqReady, rspValid}, 3'b100);
      memRspValid = 1'b1;
      memRspData = ent;
      @(posedge clk);
      @(negedge clk);
      memRspValid = 1'b0;
      memRspData = '0;
      pa = rspPaddr;
      flt = rspFault;
      if (ent[MW]) begin
        check(rspValid && !rspFault && rspPaddr == {ent[MW-1:0], off}, "R4",
              "walk physical address", {rspValid, rspFault, rspPaddr},
              {1'b1, 1'b0, ent[MW-1:0], off});
        mFill(vpn, ent[MW-1:0]);
      end else begin
        check(rspValid && rspFault, "R6", "fault response",
              {rspValid, rspFault}, 2'b11);
      end
      check(reqReady && !memReqValid, "R3", "idle after walk",
            {reqReady, memReqValid}, 2'b10);
    end
  endtask

  task automatic doInv(input logic [VW-1:0] vpn);
    @(negedge clk);
    invValid = 1'b1;
    invVpn = vpn;
    @(posedge clk);
    @(negedge clk);
    invValid = 1'b0;
    mInv(vpn);
  endtask

  task automatic loadBase(input logic [MAW-1:0] b);
    @(negedge clk);
    baseLoad = 1'b1;
    baseData = b;
    @(posedge clk);
    @(negedge clk);
    baseLoad = 1'b0;
    mBase = b;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(reqReady && !rspValid && !memReqValid, "R9", "reset outputs",
          {reqReady, rspValid, memReqValid}, 3'b100);
    rstN = 1'b1;
    mClear();
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [MW+PW-1:0] pa;
    logic flt;
    mClear();
    doReset();
    loadBase(32'h0010_0000);

    // Reference scenario: VPN 6 -> PPN 2, VPN 4 -> PPN 5, VPN 0 faults
    translate(32'h1800, "R3", "R10", pa, flt);
    translate(32'h1804, "R5", "R3", pa, flt);
    check(pa == 24'h804 && !flt, "R1", "0x1804 translation", pa, 24'h804);
    translate(32'h1080, "R3", "R3", pa, flt);
    check(pa == 24'h1480 && !flt, "R4", "0x1080 translation", pa, 24'h1480);
    translate(32'h00FC, "R3", "R3", pa, flt);
    check(flt == 1'b1, "R6", "0x0FC faults", flt, 1);
    translate(32'h00FC, "R6", "R3", pa, flt);
    translate(32'h1080, "R5", "R3", pa, flt);

    // Invalidate of a cached page and of an absent page
    doInv(22'h6);
    translate(32'h1804, "R7", "R3", pa, flt);
    doInv(22'h123);
    translate(32'h1080, "R7", "R3", pa, flt);
    translate(32'h1804, "R7", "R3", pa, flt);

    // Replacement sweep from an empty cache
    doReset();
    loadBase(32'h0004_0000);
    for (int k = 0; k < 400; k++) begin
      logic [VW-1:0] vpn;
      vpn = VW'((k * 7 + k / 3) % 23);
      if (k % 13 == 12) doInv(VW'(k % 11));
      if (k % 97 == 96) loadBase(32'h0004_0000 + 32'(k) * 32'h100);
      translate({vpn, PW'((k * 37) & 1023)}, "R8",
                (k % 97 < 3) ? "R10" : "R3", pa, flt);
    end

    // Reset in the middle of use forgets every translation
    translate(32'h1804, "R8", "R3", pa, flt);
    doReset();
    translate(32'h1804, "R9", "R9", pa, flt);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule